// File: doc/BRIEF.md
# Serial Flash Slave Front End with Clock-Qualified Hold

This block sits at the pin edge of a serial-flash-style slave. It brings the four serial pins (active-low select, serial clock, serial data in, active-low hold) into a fast system clock through two-flop synchronisers. It then shifts command bytes in most-significant bit first on each rising serial clock. It shifts a response byte out on each falling serial clock, behind an output-enable that models a tri-stated pin. A pause input lets the host freeze a transfer mid-byte. The pause only starts or ends at a point where the serial clock is low. While paused, the clock and data pins are ignored and the output is released.

If the host deselects the part while paused, the serial logic is cleared. The block then refuses all traffic until the pause pin has gone high with the part deselected, so a fresh selection cannot fall straight back into a pause. Beside the serial path, a combinational decoder turns a three-bit protect code and a 21-bit byte address into a write-blocked flag. That flag gates a program/erase request strobe. A busy flag models the resulting internal operation and is left alone by the pause.

Top module: `sfl_hold_front`

## Requirements
- R1: Data in is captured on each rising serial clock while selected, first bit into bit 7. After the eighth bit, `cmd_byte` holds the byte and `cmd_valid` is high for exactly one system clock. Deselection clears any partial byte.
- R2: With the part selected and the serial clock low, a falling hold pin starts the pause (`hold_active`=1) within four system clocks. A rising hold pin with the clock low ends it within four system clocks.
- R3: If the hold pin changes while the serial clock is high, the pause start or end is deferred until the serial clock next goes low.
- R4: While paused, `so_oe` is 0. Serial clock and data pins have no effect, and a byte interrupted by a pause completes with its original bits after the pause ends.
- R5: A low hold pin while deselected never starts a pause.
- R6: Deselection during a pause ends it and clears the partial byte. Afterwards no byte is accepted and no pause starts until the hold pin is high while deselected. Only the next selection after that works normally.
- R7: `wp_block` is 1 when `pe_addr` lies in the range given by `bp_code`. Code 0: none. Codes 1..5: from 0x1FF000, 0x1FE000, 0x1FC000, 0x1F8000 and 0x1F0000 respectively, up to 0x1FFFFF. Code 6: 0x100000 and above. Code 7: every address.
- R8: A one-cycle `pe_req` yields a one-cycle `pe_go` on the next clock only if `wp_block` is 0 and `busy` is 0. `pe_go` sets `busy`, and only `op_done` clears it. A pause does not clear it.
- R9: On each selection `tx_byte` is loaded and driven on `so_dat` most-significant bit first. Each bit is advanced on a falling serial clock and reloaded after every eighth bit. `so_oe` is 1 while selected and not paused or blocked.
- R10: After reset `so_oe`, `hold_active`, `cmd_valid`, `pe_go` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_cs_n | input | 1 | Active-low select pin (asynchronous) |
| pin_sck | input | 1 | Serial clock pin (asynchronous) |
| pin_mosi | input | 1 | Serial data in pin (asynchronous) |
| pin_hold_n | input | 1 | Active-low pause pin (asynchronous) |
| tx_byte | input | 8 | Response byte to shift out |
| so_dat | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the data out pad |
| hold_active | output | 1 | Pause in effect |
| cmd_byte | output | 8 | Last captured byte |
| cmd_valid | output | 1 | One-cycle strobe for a new byte |
| bp_code | input | 3 | Protect range code |
| pe_addr | input | 21 | Address of a program/erase request |
| pe_req | input | 1 | Program/erase request strobe |
| op_done | input | 1 | Internal operation finished |
| wp_block | output | 1 | Address is write protected (combinational) |
| pe_go | output | 1 | Accepted program/erase strobe |
| busy | output | 1 | Internal operation in progress |

## Verification
A pause state that is entered or left at the wrong clock level shows up as an extra or missing bit. Within one byte time, the captured byte is then shifted by one position, or `so_oe` toggles while the serial clock is high. A lock state that never clears, or clears too early, appears on the next selection. In the first case no `cmd_valid` follows eight bits. In the second, a low hold pin pauses the part again. A wrong protect boundary is visible on `wp_block` at once and on `pe_go` one clock later. A busy flag disturbed by a pause lets a second request through on the next clock.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  typedef enum logic [1:0] {
    HS_RUN  = 2'd0,
    HS_HELD = 2'd1,
    HS_LOCK = 2'd2
  } hold_st_e;

  typedef struct packed {
    logic cs_n;
    logic hold_n;
    logic sck;
    logic mosi;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, hold_n: 1'b1, sck: 1'b0, mosi: 1'b0};

endpackage

// File: rtl/sfl_sync.sv
module sfl_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stg[i] <= RST_VAL;
        end else if (i == 0) begin
          stg[i] <= d;
        end else begin
          stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sfl_hold_fsm.sv
module sfl_hold_fsm
  import sfl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic hold_n,
  input  logic sck,
  output logic held,
  output logic locked
);

  hold_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= HS_RUN;
    end else begin
      unique case (st)
        HS_RUN:  if (!cs_n && !hold_n && !sck) st <= HS_HELD;
        HS_HELD: begin
          if (cs_n)                st <= HS_LOCK;
          else if (hold_n && !sck) st <= HS_RUN;
        end
        HS_LOCK: if (cs_n && hold_n) st <= HS_RUN;
        default: st <= HS_RUN;
      endcase
    end
  end

  assign held   = (st == HS_HELD);
  assign locked = (st == HS_LOCK);

  // R3: a pause only begins at a low serial clock
  p_enter_clk_low_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> !$past(sck));

  // R3: a pause ended by the hold pin ends at a low serial clock
  p_exit_clk_low_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(held) && !$past(cs_n)) |-> !$past(sck));

  // R5: no pause starts while deselected
  p_enter_selected_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> !$past(cs_n));

  // R6: the lock clears only with hold high while deselected
  p_lock_exit_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(cs_n) && $past(hold_n)));

endmodule

// File: rtl/sfl_shift.sv
module sfl_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              active,
  input  logic              sck,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_valid,
  output logic              so_dat
);

  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic              sck_q, clear_q;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic              rise, fall, sel_start;

  assign rise      = sck && !sck_q;
  assign fall      = !sck && sck_q;
  assign sel_start = !clear && clear_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q     <= 1'b0;
      clear_q   <= 1'b1;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      cmd_byte  <= '0;
      cmd_valid <= 1'b0;
    end else begin
      sck_q     <= sck;
      clear_q   <= clear;
      cmd_valid <= 1'b0;
      if (clear) begin
        bitcnt <= '0;
        shreg  <= '0;
      end else if (active && rise) begin
        shreg <= {shreg[BYTE_W-2:0], mosi};
        if (bitcnt == LAST) begin
          bitcnt    <= '0;
          cmd_byte  <= {shreg[BYTE_W-2:0], mosi};
          cmd_valid <= 1'b1;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
      if (sel_start) begin
        txreg <= tx_byte;
      end else if (active && fall) begin
        txreg <= (bitcnt == '0) ? tx_byte : {txreg[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign so_dat = txreg[BYTE_W-1];

  // R1: the byte strobe lasts one system clock
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R4: while not allowed to shift, the shift state is frozen
  p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!active && !clear) |=> ($stable(bitcnt) && $stable(shreg)));

endmodule

// File: rtl/sfl_wp_decode.sv
module sfl_wp_decode #(
  parameter int ADDR_W = 21,
  parameter int SECT_SHIFT = 12
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);

  logic [ADDR_W-1:0] mask;

  always_comb begin
    mask = {ADDR_W{1'b1}} << (SECT_SHIFT + int'(code) - 1);
    unique case (code)
      3'd0:    prot = 1'b0;
      3'd6:    prot = addr[ADDR_W-1];
      3'd7:    prot = 1'b1;
      default: prot = ((addr & mask) == mask);
    endcase
  end

endmodule

// File: rtl/sfl_hold_front.sv
module sfl_hold_front
  import sfl_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 21,
  parameter int SECT_SHIFT = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pin_cs_n,
  input  logic              pin_sck,
  input  logic              pin_mosi,
  input  logic              pin_hold_n,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              so_dat,
  output logic              so_oe,
  output logic              hold_active,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_valid,
  input  logic [2:0]        bp_code,
  input  logic [ADDR_W-1:0] pe_addr,
  input  logic              pe_req,
  input  logic              op_done,
  output logic              wp_block,
  output logic              pe_go,
  output logic              busy
);

  pins_t pins_raw, pins_s;
  logic  held, locked, active;

  assign pins_raw = '{cs_n: pin_cs_n, hold_n: pin_hold_n, sck: pin_sck, mosi: pin_mosi};

  sfl_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  sfl_hold_fsm u_hold (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (pins_s.cs_n),
    .hold_n (pins_s.hold_n),
    .sck    (pins_s.sck),
    .held   (held),
    .locked (locked)
  );

  assign active      = !pins_s.cs_n && !held && !locked;
  assign hold_active = held;

  sfl_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .clear     (pins_s.cs_n),
    .active    (active),
    .sck       (pins_s.sck),
    .mosi      (pins_s.mosi),
    .tx_byte   (tx_byte),
    .cmd_byte  (cmd_byte),
    .cmd_valid (cmd_valid),
    .so_dat    (so_dat)
  );

  sfl_wp_decode #(.ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT)) u_wp (
    .code (bp_code),
    .addr (pe_addr),
    .prot (wp_block)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      so_oe <= 1'b0;
      pe_go <= 1'b0;
      busy  <= 1'b0;
    end else begin
      so_oe <= active;
      pe_go <= pe_req && !wp_block && !busy;
      if (pe_req && !wp_block && !busy) busy <= 1'b1;
      else if (op_done)                 busy <= 1'b0;
    end
  end

  // R4: output released in the clock after a pause or lock is seen
  p_oe_off_r4: assert property (@(posedge clk) disable iff (rst)
    (held || locked) |=> !so_oe);

  // R8: an accepted request never follows a protected address or busy
  p_go_allowed_r8: assert property (@(posedge clk) disable iff (rst)
    pe_go |-> (!$past(wp_block) && !$past(busy)));

  // R8: busy holds until op_done, whatever the pause does
  p_busy_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_done) |=> busy);

  // R6: no byte completes while locked
  p_lock_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> !cmd_valid);

endmodule

// File: tb/sfl_hold_front_test.sv
module sfl_hold_front_test;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pin_cs_n = 1'b1, pin_sck = 1'b0, pin_mosi = 1'b0, pin_hold_n = 1'b1;
  logic [7:0]  tx_byte = 8'h00;
  logic        so_dat, so_oe, hold_active, cmd_valid, wp_block, pe_go, busy;
  logic [7:0]  cmd_byte;
  logic [2:0]  bp_code = 3'd0;
  logic [20:0] pe_addr = '0;
  logic        pe_req = 1'b0, op_done = 1'b0;

  int checks = 0, fails = 0;
  int vcnt = 0, gocnt = 0;
  logic [7:0] last_cmd = 8'h00;
  bit finished = 0;

  always #2 clk = ~clk;

  sfl_hold_front uut (
    .clk(clk), .rst(rst), .pin_cs_n(pin_cs_n), .pin_sck(pin_sck), .pin_mosi(pin_mosi),
    .pin_hold_n(pin_hold_n), .tx_byte(tx_byte), .so_dat(so_dat), .so_oe(so_oe),
    .hold_active(hold_active), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
    .bp_code(bp_code), .pe_addr(pe_addr), .pe_req(pe_req), .op_done(op_done),
    .wp_block(wp_block), .pe_go(pe_go), .busy(busy)
  );

  always @(posedge clk) begin
    if (cmd_valid) begin vcnt <= vcnt + 1; last_cmd <= cmd_byte; end
    if (pe_go) gocnt <= gocnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_wp(input logic [2:0] c, input logic [20:0] a);
    case (c)
      3'd0: return 1'b0;
      3'd1: return a >= 21'h1FF000;
      3'd2: return a >= 21'h1FE000;
      3'd3: return a >= 21'h1FC000;
      3'd4: return a >= 21'h1F8000;
      3'd5: return a >= 21'h1F0000;
      3'd6: return a >= 21'h100000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic so);
    pin_mosi = b;
    wait_clk(HALF);
    so = so_dat;
    pin_sck = 1'b1;
    wait_clk(HALF);
    pin_sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic [7:0] so_b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      xbit(d[i], s);
      so_b[i] = s;
    end
    wait_clk(HALF);
  endtask

  task automatic select(input logic [7:0] tx);
    tx_byte = tx;
    pin_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic deselect();
    wait_clk(2);
    pin_cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] so_b, d, tx;
    logic s;
    int v0;
    void'($urandom(32'd1234));
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);

    // R10 reset state
    chk(!so_oe && !hold_active && !cmd_valid && !pe_go && !busy, "R10 reset",
        {so_oe, hold_active, cmd_valid, pe_go, busy}, 0);

    // R1 R9 random transfers
    for (int t = 0; t < 30; t++) begin
      tx = 8'($urandom);
      select(tx);
      chk(so_oe == 1'b1, "R9 oe selected", so_oe, 1);
      for (int b = 0; b < 1 + int'($urandom % 3); b++) begin
        d = 8'($urandom);
        v0 = vcnt;
        send_byte(d, so_b);
        chk(vcnt == v0 + 1 && last_cmd == d, "R1 byte", last_cmd, d);
        chk(so_b == tx, "R9 out byte", so_b, tx);
      end
      deselect();
      chk(so_oe == 1'b0, "R9 oe deselected", so_oe, 0);
    end

    // R1 partial byte discarded on deselect
    select(8'h00);
    for (int i = 0; i < 3; i++) xbit(1'b1, s);
    deselect();
    select(8'h00);
    v0 = vcnt;
    send_byte(8'h5A, so_b);
    chk(vcnt == v0 + 1 && last_cmd == 8'h5A, "R1 partial cleared", last_cmd, 8'h5A);
    deselect();

    // R2 R4 pause mid-byte with clock low
    select(8'hC3);
    d = 8'hA7;
    for (int i = 7; i >= 4; i--) begin xbit(d[i], s); so_b[i] = s; end
    wait_clk(HALF);
    pin_hold_n = 1'b0;
    wait_clk(4);
    chk(hold_active == 1'b1, "R2 enter", hold_active, 1);
    wait_clk(1);
    chk(so_oe == 1'b0, "R4 oe off", so_oe, 0);
    v0 = vcnt;
    for (int i = 0; i < 6; i++) xbit(1'($urandom), s);
    wait_clk(HALF);
    chk(vcnt == v0 && hold_active == 1'b1, "R4 ignored", vcnt, v0);
    pin_hold_n = 1'b1;
    wait_clk(4);
    chk(hold_active == 1'b0, "R2 exit", hold_active, 0);
    for (int i = 3; i >= 0; i--) begin xbit(d[i], s); so_b[i] = s; end
    wait_clk(HALF);
    chk(vcnt == v0 + 1 && last_cmd == d, "R4 resumed byte", last_cmd, d);
    chk(so_b == 8'hC3, "R4 R9 out across pause", so_b, 8'hC3);
    deselect();

    // R3 deferred entry and exit
    select(8'h00);
    d = 8'h96;
    pin_mosi = d[7];
    wait_clk(HALF);
    pin_sck = 1'b1;
    wait_clk(HALF);
    pin_hold_n = 1'b0;
    wait_clk(10);
    chk(hold_active == 1'b0, "R3 entry deferred", hold_active, 0);
    pin_sck = 1'b0;
    wait_clk(5);
    chk(hold_active == 1'b1, "R3 entry at clock low", hold_active, 1);
    pin_mosi = 1'b1;
    pin_sck = 1'b1;
    wait_clk(HALF);
    pin_hold_n = 1'b1;
    wait_clk(10);
    chk(hold_active == 1'b1, "R3 exit deferred", hold_active, 1);
    pin_sck = 1'b0;
    wait_clk(5);
    chk(hold_active == 1'b0, "R3 exit at clock low", hold_active, 0);
    v0 = vcnt;
    for (int i = 6; i >= 0; i--) xbit(d[i], s);
    wait_clk(HALF);
    chk(vcnt == v0 + 1 && last_cmd == d, "R3 byte intact", last_cmd, d);
    deselect();

    // R5 no pause while deselected
    pin_hold_n = 1'b0;
    wait_clk(8);
    chk(hold_active == 1'b0, "R5 deselected", hold_active, 0);
    pin_hold_n = 1'b1;
    wait_clk(4);

    // R6 deselect during pause
    select(8'h00);
    for (int i = 0; i < 3; i++) xbit(1'b1, s);
    wait_clk(HALF);
    pin_hold_n = 1'b0;
    wait_clk(5);
    chk(hold_active == 1'b1, "R6 paused", hold_active, 1);
    pin_cs_n = 1'b1;
    wait_clk(5);
    chk(hold_active == 1'b0, "R6 pause ended", hold_active, 0);
    pin_cs_n = 1'b0;
    wait_clk(HALF);
    chk(hold_active == 1'b0 && so_oe == 1'b0, "R6 no re-pause", {hold_active, so_oe}, 0);
    v0 = vcnt;
    pin_hold_n = 1'b1;
    send_byte(8'h3C, so_b);
    chk(vcnt == v0, "R6 locked", vcnt, v0);
    deselect();
    select(8'h00);
    send_byte(8'hE1, so_b);
    chk(vcnt == v0 + 1 && last_cmd == 8'hE1, "R6 recovered", last_cmd, 8'hE1);
    deselect();

    // R7 boundaries and random addresses
    for (int c = 0; c < 8; c++) begin
      logic [20:0] lim [8];
      lim = '{21'h0, 21'h1FF000, 21'h1FE000, 21'h1FC000, 21'h1F8000, 21'h1F0000, 21'h100000, 21'h0};
      bp_code = 3'(c);
      pe_addr = lim[c]; #1;
      chk(wp_block == exp_wp(bp_code, pe_addr), "R7 boundary", wp_block, exp_wp(bp_code, pe_addr));
      pe_addr = lim[c] - 21'd1; #1;
      chk(wp_block == exp_wp(bp_code, pe_addr), "R7 below", wp_block, exp_wp(bp_code, pe_addr));
    end
    for (int k = 0; k < 200; k++) begin
      bp_code = 3'($urandom);
      pe_addr = ($urandom % 2) ? 21'($urandom) : (21'h1E0000 | 21'($urandom % 21'h20000));
      #1;
      chk(wp_block == exp_wp(bp_code, pe_addr), "R7 random", wp_block, exp_wp(bp_code, pe_addr));
    end
    @(negedge clk);

    // R8 request gating and busy
    bp_code = 3'd1;
    pe_addr = 21'h1FF800;
    v0 = gocnt;
    pe_req = 1'b1; wait_clk(1); pe_req = 1'b0; wait_clk(2);
    chk(gocnt == v0 && !busy, "R8 protected blocked", gocnt, v0);
    pe_addr = 21'h000100;
    pe_req = 1'b1; wait_clk(1); pe_req = 1'b0; wait_clk(2);
    chk(gocnt == v0 + 1 && busy, "R8 accepted", gocnt, v0 + 1);
    select(8'h00);
    xbit(1'b0, s);
    wait_clk(HALF);
    pin_hold_n = 1'b0;
    wait_clk(8);
    chk(busy == 1'b1, "R8 busy through pause", busy, 1);
    pe_req = 1'b1; wait_clk(1); pe_req = 1'b0; wait_clk(2);
    chk(gocnt == v0 + 1, "R8 busy blocks", gocnt, v0 + 1);
    pin_hold_n = 1'b1;
    wait_clk(4);
    deselect();
    op_done = 1'b1; wait_clk(1); op_done = 1'b0; wait_clk(1);
    chk(busy == 1'b0, "R8 done clears", busy, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule